// File: doc/BRIEF.md
# Transfer-Triggered Output Freeze Latch

This block stands between a position word that changes every clock and the output port that an external controller reads. While nothing is pending, the output register copies the live word on every clock, so the port shows it one cycle late. When the controller wants a stable reading, it changes the level of a transfer input. Once the new level has been held long enough to count as a genuine strobe, the block captures the live word and holds it on the port for a fixed window of about 100 µs. After that window the port follows the live word again.

The transfer input is asynchronous. It passes through a two-flop synchronizer before edge detection. A two-bit trigger-mode input selects which transitions start a freeze. Code 2'b00 and code 2'b11 accept both edges, which is the standard behaviour. Code 2'b01 accepts rising edges only and code 2'b10 accepts falling edges only. The parameter `CLK_HZ` sets a prescaler that produces a 1 µs tick. The minimum strobe width `MIN_WIDTH_US` (default 30) and the hold window `HOLD_US` (default 100) are counted in these ticks. The prescaler and the tick counter are restarted when the block enters a state, so every timing is exact to the cycle. Let D = CLK_HZ/1e6, M = MIN_WIDTH_US·D and H = HOLD_US·D.

The controller has three states. IDLE is transparent. QUALIFY is also transparent and measures the width of the new level. HOLD is frozen, and the `busy_o` output is high in HOLD. The transitions are:
- ARM goes from IDLE to QUALIFY on an enabled edge.
- REJECT goes from QUALIFY to IDLE when the synchronized input leaves the new level.
- FREEZE goes from QUALIFY to HOLD when the width count completes.
- RELEASE goes from HOLD to IDLE when the hold count completes.

Top module: `xfer_freeze_latch`

## Requirements
- R1: While `busy_o` is low, `pos_o` equals the value that `pos_i` had on the previous clock edge.
- R2: While reset is active, and until the first clock edge after reset, `pos_o` is 0 and `busy_o` is 0.
- R3: The mode codes behave as follows. Code 2'b01 starts a freeze on rising transfer edges only. Code 2'b10 starts a freeze on falling edges only. Codes 2'b00 and 2'b11 start a freeze on both edges.
- R4: The transfer input changes before clock edge k. For an accepted strobe, `busy_o` is first high after clock edge k+M+1, which is within about 30 µs of the transition.
- R5: A new level held for at least M clock edges starts a freeze. A level held for M-1 edges or fewer starts no freeze, and its return transition starts none either.
- R6: `busy_o` stays high for exactly H consecutive cycles per freeze.
- R7: Transfer edges that occur while `busy_o` is high neither extend nor restart the window, and they start no later freeze.
- R8: Throughout a freeze, `pos_o` holds the value that `pos_i` had just before the clock edge on which `busy_o` rose.
- R9: `busy_o` rises only on a FREEZE transition, and it is never high in IDLE or QUALIFY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_mode_i | input | 2 | Trigger edge selection (see R3) |
| xfer_i | input | 1 | Asynchronous transfer or strobe input |
| pos_i | input | WORD_W | Live position word |
| pos_o | output | WORD_W | Transparent or frozen position word |
| busy_o | output | 1 | High during the hold window |

## Verification
The width qualifier and the abort check can fall in the same cycle. A strobe held for exactly M or M-1 edges brings the completion of the width count and the return of the input together. The bench sends both widths, in the single-edge mode and in the both-edges mode. It judges the outcome by whether `busy_o` rises on edge M+2 or not at all. Edges that land inside a running hold window are provoked by toggling the input repeatedly during HOLD. The bench then checks that the window still ends exactly H cycles after it began, and that the freeze count rises by one.

// File: rtl/xfer_freeze_pkg.sv
package xfer_freeze_pkg;

    typedef enum logic [1:0] {
        FRZ_IDLE = 2'd0,
        FRZ_QUAL = 2'd1,
        FRZ_HOLD = 2'd2
    } frz_state_e;

    typedef enum logic [1:0] {
        TRIG_ANY     = 2'b00,
        TRIG_RISE    = 2'b01,
        TRIG_FALL    = 2'b10,
        TRIG_ANY_ALT = 2'b11
    } trig_mode_e;

endpackage

// File: rtl/xfer_sync_edge.sv
module xfer_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    logic meta_q;
    logic sync_q;
    logic last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            last_q <= 1'b0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    assign level_o = sync_q;
    assign rise_o  = sync_q & ~last_q;
    assign fall_o  = ~sync_q & last_q;
endmodule

// File: rtl/xfer_tick_timer.sv
module xfer_tick_timer #(
    parameter int DIV   = 4,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             start_one_i,
    output logic             tick_o,
    output logic [CNT_W-1:0] count_o
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);
    localparam logic [PW-1:0] ONE  = PW'(1);

    logic [PW-1:0]    presc_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc_q <= '0;
            cnt_q   <= '0;
        end else if (restart_i) begin
            presc_q <= start_one_i ? ONE : '0;
            cnt_q   <= '0;
        end else if (presc_q == LAST) begin
            presc_q <= '0;
            cnt_q   <= cnt_q + 1'b1;
        end else begin
            presc_q <= presc_q + 1'b1;
        end
    end

    assign tick_o  = (presc_q == LAST);
    assign count_o = cnt_q;
endmodule

// File: rtl/xfer_freeze_fsm.sv
module xfer_freeze_fsm
    import xfer_freeze_pkg::*;
#(
    parameter int QUAL_TICKS = 30,
    parameter int HOLD_TICKS = 100,
    parameter int CNT_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic             level_i,
    input  logic             rise_i,
    input  logic             fall_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] count_i,
    output frz_state_e       state_o,
    output logic             restart_o,
    output logic             start_one_o,
    output logic             load_en_o
);
    localparam logic [CNT_W-1:0] QUAL_LAST = CNT_W'(QUAL_TICKS - 1);
    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_TICKS - 1);

    frz_state_e state_q;
    frz_state_e state_d;
    logic       target_q;
    trig_mode_e mode;
    logic       edge_ok;
    logic       qual_done;
    logic       hold_done;

    assign mode      = trig_mode_e'(mode_i);
    assign edge_ok   = (rise_i && mode != TRIG_FALL) || (fall_i && mode != TRIG_RISE);
    assign qual_done = tick_i && (count_i == QUAL_LAST);
    assign hold_done = tick_i && (count_i == HOLD_LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= FRZ_IDLE;
            target_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == FRZ_IDLE && edge_ok) begin
                target_q <= level_i;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FRZ_IDLE: if (edge_ok) state_d = FRZ_QUAL;
            FRZ_QUAL: begin
                if (level_i != target_q) state_d = FRZ_IDLE;
                else if (qual_done)      state_d = FRZ_HOLD;
            end
            FRZ_HOLD: if (hold_done) state_d = FRZ_IDLE;
            default:  state_d = FRZ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        restart_o   = 1'b0;
        start_one_o = 1'b0;
        load_en_o   = 1'b1;
        unique case (state_q)
            FRZ_IDLE: begin
                restart_o   = (state_d == FRZ_QUAL);
                start_one_o = 1'b1;
            end
            FRZ_QUAL: restart_o = (state_d == FRZ_HOLD);
            FRZ_HOLD: load_en_o = (state_d != FRZ_HOLD);
            default:  load_en_o = 1'b1;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/xfer_freeze_latch.sv
module xfer_freeze_latch
    import xfer_freeze_pkg::*;
#(
    parameter int CLK_HZ       = 50_000_000,
    parameter int WORD_W       = 16,
    parameter int MIN_WIDTH_US = 30,
    parameter int HOLD_US      = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        trig_mode_i,
    input  logic              xfer_i,
    input  logic [WORD_W-1:0] pos_i,
    output logic [WORD_W-1:0] pos_o,
    output logic              busy_o
);
    localparam int TICK_DIV = CLK_HZ / 1_000_000;
    localparam int MAX_TICK = (HOLD_US > MIN_WIDTH_US) ? HOLD_US : MIN_WIDTH_US;
    localparam int CNT_W    = $clog2(MAX_TICK + 1);
    localparam int HOLD_CYC = HOLD_US * TICK_DIV;

    frz_state_e       cur_state;
    logic             sync_level;
    logic             edge_rise;
    logic             edge_fall;
    logic             tick;
    logic [CNT_W-1:0] tick_count;
    logic             restart;
    logic             start_one;
    logic             load_en;
    logic [WORD_W-1:0] word_q;

    xfer_sync_edge u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (xfer_i),
        .level_o (sync_level),
        .rise_o  (edge_rise),
        .fall_o  (edge_fall)
    );

    xfer_tick_timer #(.DIV(TICK_DIV), .CNT_W(CNT_W)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart_i   (restart),
        .start_one_i (start_one),
        .tick_o      (tick),
        .count_o     (tick_count)
    );

    xfer_freeze_fsm #(
        .QUAL_TICKS (MIN_WIDTH_US),
        .HOLD_TICKS (HOLD_US),
        .CNT_W      (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (trig_mode_i),
        .level_i     (sync_level),
        .rise_i      (edge_rise),
        .fall_i      (edge_fall),
        .tick_i      (tick),
        .count_i     (tick_count),
        .state_o     (cur_state),
        .restart_o   (restart),
        .start_one_o (start_one),
        .load_en_o   (load_en)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       word_q <= '0;
        else if (load_en) word_q <= pos_i;
    end

    assign pos_o  = word_q;
    assign busy_o = (cur_state == FRZ_HOLD);
endmodule

// File: rtl/xfer_freeze_latch_chk.sv
module xfer_freeze_latch_chk
    import xfer_freeze_pkg::*;
#(
    parameter int WORD_W   = 16,
    parameter int HOLD_CYC = 400
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        trig_mode_i,
    input logic [WORD_W-1:0] pos_i,
    input logic [WORD_W-1:0] pos_o,
    input logic              busy_o,
    input frz_state_e        cur_state,
    input logic              edge_rise,
    input logic              edge_fall
);
    localparam int RW = $clog2(HOLD_CYC + 1) + 1;
    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      run_q <= '0;
        else if (busy_o) run_q <= run_q + 1'b1;
        else             run_q <= '0;
    end

    AST_TRANSPARENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && $past(rst_n)) |-> (pos_o == $past(pos_i))); // R1
    AST_FROZEN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(pos_o)); // R8
    AST_HOLD_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (run_q == RW'(HOLD_CYC))); // R6
    AST_HOLD_NO_EXTEND: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (run_q < RW'(HOLD_CYC))); // R7
    AST_FREEZE_FROM_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> ($past(cur_state) == FRZ_QUAL)); // R9
    AST_TRIG_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == FRZ_QUAL && $past(cur_state) == FRZ_IDLE) |->
        $past((edge_rise && trig_mode_i != 2'b10) || (edge_fall && trig_mode_i != 2'b01))); // R3
endmodule

bind xfer_freeze_latch xfer_freeze_latch_chk #(
    .WORD_W   (WORD_W),
    .HOLD_CYC (HOLD_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig_mode_i (trig_mode_i),
    .pos_i       (pos_i),
    .pos_o       (pos_o),
    .busy_o      (busy_o),
    .cur_state   (cur_state),
    .edge_rise   (edge_rise),
    .edge_fall   (edge_fall)
);

// File: tb/xfer_freeze_latch_tb.sv
module xfer_freeze_latch_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 4_000_000;
    localparam int W          = 12;
    localparam int MIN_US     = 30;
    localparam int HOLD_US    = 100;
    localparam int PER_US     = CLK_HZ / 1_000_000;
    localparam int M_CYC      = MIN_US * PER_US;
    localparam int H_CYC      = HOLD_US * PER_US;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   trig_mode_i = 2'b00;
    logic         xfer_i = 1'b0;
    logic [W-1:0] pos_i = '0;
    logic [W-1:0] pos_o;
    logic         busy_o;

    int checks = 0;
    int fails = 0;
    int freezes = 0;
    int tr_err = 0;
    int fz_err = 0;
    bit mon_on = 1'b0;
    bit finished = 1'b0;
    logic [W-1:0] prev_pos = '0;
    logic [W-1:0] frozen_exp = '0;
    logic prev_busy = 1'b0;
    int run = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xfer_freeze_latch #(
        .CLK_HZ(CLK_HZ), .WORD_W(W), .MIN_WIDTH_US(MIN_US), .HOLD_US(HOLD_US)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .trig_mode_i(trig_mode_i), .xfer_i(xfer_i),
        .pos_i(pos_i), .pos_o(pos_o), .busy_o(busy_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // monitor and live-word driver, all at the falling edge
    always @(negedge clk) begin
        if (mon_on) begin
            if (busy_o) begin
                if (!prev_busy) begin
                    freezes++;
                    frozen_exp = prev_pos;
                    run = 0;
                    chk(pos_o == prev_pos, "R8", "captured word", int'(pos_o), int'(prev_pos));
                end
                if (pos_o != frozen_exp) fz_err++;
                run++;
            end else begin
                if (prev_busy)
                    chk(run == H_CYC, "R6", "hold length", run, H_CYC);
                if (pos_o != prev_pos) tr_err++;
            end
            prev_busy = busy_o;
        end
        prev_pos = pos_i + W'(37);
        pos_i <= prev_pos;
    end

    // drive lvl, optionally return after width edges; report first busy cycle
    task automatic stim(input logic lvl, input int width, output int lat);
        lat = 0;
        @(negedge clk);
        xfer_i = lvl;
        for (int i = 1; i <= M_CYC + 8; i++) begin
            @(negedge clk);
            if (busy_o && lat == 0) lat = i;
            if (i == width) xfer_i = ~lvl;
        end
        while (busy_o) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150_000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired: actual 1 expected 0");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        int lat;
        int f0;
        repeat (3) @(negedge clk);
        // R2: reset state
        chk(pos_o == '0, "R2", "pos_o in reset", int'(pos_o), 0);
        chk(busy_o == 1'b0, "R2", "busy_o in reset", int'(busy_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;
        repeat (40) @(negedge clk);
        chk(busy_o == 1'b0, "R9", "busy idle without strobe", int'(busy_o), 0);

        // R3/R4: every mode, rising then falling long strobes
        for (int m = 0; m < 4; m++) begin
            trig_mode_i = 2'(m);
            f0 = freezes;
            stim(1'b1, 0, lat);
            chk(lat == ((m != 2) ? M_CYC + 2 : 0), "R3", "rise latency per mode", lat,
                (m != 2) ? M_CYC + 2 : 0);
            stim(1'b0, 0, lat);
            chk(lat == ((m != 1) ? M_CYC + 2 : 0), "R4", "fall latency per mode", lat,
                (m != 1) ? M_CYC + 2 : 0);
            chk(freezes - f0 == ((m == 0 || m == 3) ? 2 : 1), "R3", "freezes per mode",
                freezes - f0, (m == 0 || m == 3) ? 2 : 1);
        end

        // R5: width boundary, rise-only mode and both-edges mode
        for (int md = 0; md < 2; md++) begin
            trig_mode_i = (md == 0) ? 2'b01 : 2'b00;
            for (int k = 0; k < 5; k++) begin
                int w;
                int e;
                w = (k == 0) ? 1 : M_CYC - 3 + k;
                e = (w >= M_CYC) ? M_CYC + 2 : 0;
                f0 = freezes;
                stim(1'b1, w, lat);
                chk(lat == e, "R5", "strobe width accept", lat, e);
                chk(freezes - f0 == ((w >= M_CYC) ? 1 : 0), "R5", "freeze count after pulse",
                    freezes - f0, (w >= M_CYC) ? 1 : 0);
            end
        end

        // R7: edges during hold, both-edges mode
        trig_mode_i = 2'b00;
        f0 = freezes;
        lat = 0;
        @(negedge clk);
        xfer_i = 1'b1;
        for (int i = 1; i <= M_CYC + H_CYC + 40; i++) begin
            @(negedge clk);
            if (i > M_CYC + 2 && i <= M_CYC + H_CYC - 60 && (i % 20) == 0) xfer_i = ~xfer_i;
            if (!busy_o && lat == 0 && i > M_CYC + 2) lat = i;
        end
        chk(lat == M_CYC + 2 + H_CYC, "R7", "hold end with edges inside", lat, M_CYC + 2 + H_CYC);
        repeat (M_CYC + 20) @(negedge clk);
        chk(freezes - f0 == 1, "R7", "no retrigger from hold edges", freezes - f0, 1);

        chk(tr_err == 0, "R1", "transparent mismatches", tr_err, 0);
        chk(fz_err == 0, "R8", "frozen word changed", fz_err, 0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule